// File: doc/BRIEF.md
# Tightly-Coupled Memory Region Hit Decoder

This block decides, for every processor access, whether the address falls inside one of two tightly-coupled memory windows. One window serves the instruction side and the other the data side. Each window is a single contiguous span whose size is a power of two between 4 KB and 256 KB. The size is fixed when the block is built, and the two sides are sized independently. A build may also leave out either window, or both.

Software places each window by writing a per-side region register. That register holds a movable base and an enable bit. The base is forced to the window's size alignment. Clearing the enable bit also wipes the stored base, so a disabled window can never give a stale match. A read-only status word reports which windows exist and how large they are.

For each side the block gives four outputs: a hit flag, a select that bypasses the cache, a flag that forces the access's attributes to normal, non-shared memory, and an array-enable strobe. It also gives the offset of the access into the memory array. The array is strobed only on a hit, so a disabled window draws no array access.

Top module: `tcm_hit_decoder`

## Requirements
- R1: After reset both windows are disabled with a zero base. Both region registers read back as zero, and no access on either side hits.
- R2: The status word is 16 bits. Bits 3:0 describe the instruction window and bits 11:8 the data window. In each nibble, bit 0 is 1 when the window is built and bits 3:1 hold log2(size)−12, so 0 means 4 KB and 6 means 256 KB. An absent window reports an all-zero nibble. All other bits are zero.
- R3: A region write is selected by `cfgWrSel`, where 0 is the instruction side and 1 the data side. Data bit 0 is the enable. Bits from log2(size) upward are the base. Readback through `cfgRdSel` returns the base in those bits and the enable in bit 0, with every bit in between reading as zero.
- R4: A side hits when its valid input is high, its window is enabled, and the address bits from log2(size) upward equal the stored base.
- R5: On a hit the offset output equals the address bits below log2(size). Without a hit the offset is zero.
- R6: On each side the cache-bypass select, the normal/non-shared attribute override and the array enable all equal the hit flag, so no array access is made while the window is disabled.
- R7: A write with bit 0 clear disables the window and clears its base. An access at the former base then misses and the register reads back zero. A later write with bit 0 set installs a new base.
- R8: A region write affects accesses from the next cycle on. An access presented in the same cycle as the write is decoded with the old settings.
- R9: In a build without a window on a side, that side never hits, its writes are ignored, its register reads back zero, and its status nibble is zero.
- R10: A write to one side leaves the other side's register and hit decoding unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Region register write strobe |
| cfgWrSel | input | 1 | Write target: 0 instruction, 1 data |
| cfgWrData | input | ADDR_W | Write value: bit 0 enable, upper bits base |
| cfgRdSel | input | 1 | Readback select: 0 instruction, 1 data |
| cfgRdData | output | ADDR_W | Selected region register contents |
| tcmStatus | output | 16 | Built-in window presence and size codes |
| iValid | input | 1 | Instruction access valid |
| iAddr | input | ADDR_W | Instruction access address |
| iHit | output | 1 | Instruction access lies in the window |
| iBypass | output | 1 | Instruction cache bypass select |
| iAttrNormal | output | 1 | Normal, non-shared attribute override |
| iArrayEn | output | 1 | Instruction array access strobe |
| iOffset | output | I_SIZE_LOG2 | Offset into the instruction array |
| dValid | input | 1 | Data access valid |
| dAddr | input | ADDR_W | Data access address |
| dHit | output | 1 | Data access lies in the window |
| dBypass | output | 1 | Data cache bypass select |
| dAttrNormal | output | 1 | Normal, non-shared attribute override |
| dArrayEn | output | 1 | Data array access strobe |
| dOffset | output | D_SIZE_LOG2 | Offset into the data array |

## Verification
The bench uses several kinds of address:
- Addresses with the base's upper bits and random low bits show that the offset is taken correctly.
- Addresses with a single upper bit flipped show that the compare covers every bit above the size boundary.
- Fully random addresses and idle cycles with valid low show that a miss cannot come from stray matches.

The bench also writes junk low bits into the base to separate correct alignment from a plain register copy. It places a write and an access in the same cycle to tell next-cycle update apart from write-through. It disables a window and then probes its old base to catch a base that is not cleared. A second instance, built without a data window, covers the absent-window case.

// File: rtl/tcm_dec_pkg.sv
package tcm_dec_pkg;
  localparam int MIN_SIZE_LOG2 = 12;
  localparam int MAX_SIZE_LOG2 = 18;
  localparam int STATUS_W      = 16;

  typedef struct packed {
    logic load;
    logic enable;
  } regionStrobe_t;

  function automatic logic [3:0] sizeNibble(input bit present, input int sizeLog2);
    logic [2:0] code;
    code = 3'(sizeLog2 - MIN_SIZE_LOG2);
    return present ? {code, 1'b1} : 4'b0000;
  endfunction
endpackage

// File: rtl/tcm_dec_ctrl.sv
module tcm_dec_ctrl
  import tcm_dec_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter bit I_PRESENT   = 1'b1,
  parameter bit D_PRESENT   = 1'b1,
  parameter int I_SIZE_LOG2 = 15,
  parameter int D_SIZE_LOG2 = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic                cfgWrSel,
  input  logic                cfgWrEnableBit,
  input  logic                cfgRdSel,
  input  logic [ADDR_W-1:0]   iView,
  input  logic [ADDR_W-1:0]   dView,
  output regionStrobe_t       iStb,
  output regionStrobe_t       dStb,
  output logic [ADDR_W-1:0]   cfgRdData,
  output logic [STATUS_W-1:0] tcmStatus
);
  always_comb begin
    iStb.load   = cfgWrEn && !cfgWrSel && I_PRESENT;
    iStb.enable = cfgWrEnableBit;
    dStb.load   = cfgWrEn && cfgWrSel && D_PRESENT;
    dStb.enable = cfgWrEnableBit;
  end

  assign cfgRdData = cfgRdSel ? dView : iView;

  assign tcmStatus = {4'b0000, sizeNibble(D_PRESENT, D_SIZE_LOG2),
                      4'b0000, sizeNibble(I_PRESENT, I_SIZE_LOG2)};

  AST_SINGLE_SIDE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({iStb.load, dStb.load})); // R10
endmodule

// File: rtl/tcm_dec_region.sv
module tcm_dec_region
  import tcm_dec_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter bit PRESENT   = 1'b1,
  parameter int SIZE_LOG2 = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regionStrobe_t        stb,
  input  logic [ADDR_W-1:0]    wrData,
  input  logic                 accValid,
  input  logic [ADDR_W-1:0]    accAddr,
  output logic                 hit,
  output logic [SIZE_LOG2-1:0] offset,
  output logic [ADDR_W-1:0]    regView
);
  localparam int BASE_W = ADDR_W - SIZE_LOG2;

  logic hitInt;

  generate
    if (PRESENT) begin : g_region
      logic              enReg;
      logic [BASE_W-1:0] baseReg;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          enReg   <= 1'b0;
          baseReg <= '0;
        end else if (stb.load) begin
          enReg   <= stb.enable;
          baseReg <= stb.enable ? wrData[ADDR_W-1:SIZE_LOG2] : '0;
        end
      end

      assign hitInt  = accValid && enReg && (accAddr[ADDR_W-1:SIZE_LOG2] == baseReg);
      assign regView = {baseReg, {(SIZE_LOG2-1){1'b0}}, enReg};
    end else begin : g_absent
      assign hitInt  = 1'b0;
      assign regView = '0;
    end
  endgenerate

  assign hit    = hitInt;
  assign offset = hitInt ? accAddr[SIZE_LOG2-1:0] : '0;

  AST_DISABLE_WIPES_BASE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && !stb.enable) |=> (regView == '0)); // R7
  AST_WRITE_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (PRESENT && stb.load && stb.enable) |=> regView[0]); // R8
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(regView)); // R10
  AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (regView[0] && accValid)); // R4
  AST_MISS_ZERO_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (offset == '0)); // R5
endmodule

// File: rtl/tcm_hit_decoder.sv
module tcm_hit_decoder
  import tcm_dec_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter bit I_PRESENT   = 1'b1,
  parameter bit D_PRESENT   = 1'b1,
  parameter int I_SIZE_LOG2 = 15,
  parameter int D_SIZE_LOG2 = 14
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrEn,
  input  logic                   cfgWrSel,
  input  logic [ADDR_W-1:0]      cfgWrData,
  input  logic                   cfgRdSel,
  output logic [ADDR_W-1:0]      cfgRdData,
  output logic [STATUS_W-1:0]    tcmStatus,
  input  logic                   iValid,
  input  logic [ADDR_W-1:0]      iAddr,
  output logic                   iHit,
  output logic                   iBypass,
  output logic                   iAttrNormal,
  output logic                   iArrayEn,
  output logic [I_SIZE_LOG2-1:0] iOffset,
  input  logic                   dValid,
  input  logic [ADDR_W-1:0]      dAddr,
  output logic                   dHit,
  output logic                   dBypass,
  output logic                   dAttrNormal,
  output logic                   dArrayEn,
  output logic [D_SIZE_LOG2-1:0] dOffset
);
  regionStrobe_t     iStb, dStb;
  logic [ADDR_W-1:0] iView, dView;

  tcm_dec_ctrl #(
    .ADDR_W(ADDR_W), .I_PRESENT(I_PRESENT), .D_PRESENT(D_PRESENT),
    .I_SIZE_LOG2(I_SIZE_LOG2), .D_SIZE_LOG2(D_SIZE_LOG2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrEnableBit(cfgWrData[0]), .cfgRdSel(cfgRdSel),
    .iView(iView), .dView(dView), .iStb(iStb), .dStb(dStb),
    .cfgRdData(cfgRdData), .tcmStatus(tcmStatus)
  );

  tcm_dec_region #(.ADDR_W(ADDR_W), .PRESENT(I_PRESENT), .SIZE_LOG2(I_SIZE_LOG2)) u_iRegion (
    .clk(clk), .rstN(rstN), .stb(iStb), .wrData(cfgWrData),
    .accValid(iValid), .accAddr(iAddr), .hit(iHit), .offset(iOffset), .regView(iView)
  );

  tcm_dec_region #(.ADDR_W(ADDR_W), .PRESENT(D_PRESENT), .SIZE_LOG2(D_SIZE_LOG2)) u_dRegion (
    .clk(clk), .rstN(rstN), .stb(dStb), .wrData(cfgWrData),
    .accValid(dValid), .accAddr(dAddr), .hit(dHit), .offset(dOffset), .regView(dView)
  );

  assign iBypass     = iHit;
  assign iAttrNormal = iHit;
  assign iArrayEn    = iHit;
  assign dBypass     = dHit;
  assign dAttrNormal = dHit;
  assign dArrayEn    = dHit;

  AST_NO_ABSENT_DATA_HIT: assert property (@(posedge clk) disable iff (!rstN)
    dArrayEn |-> (tcmStatus[8] && dHit)); // R9
  AST_NO_ABSENT_INSTR_HIT: assert property (@(posedge clk) disable iff (!rstN)
    iArrayEn |-> (tcmStatus[0] && iHit)); // R9
endmodule

// File: tb/tcm_hit_decoder_bench.sv
`timescale 1ns/1ps
module tcm_hit_decoder_bench;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0, cfgWrSel = 1'b0, cfgRdSel = 1'b0;
  logic [AW-1:0] cfgWrData = '0;
  logic iValid = 1'b0, dValid = 1'b0;
  logic [AW-1:0] iAddr = '0, dAddr = '0;

  logic [AW-1:0] cfgRdData, rd2;
  logic [15:0]   tcmStatus, st2;
  logic iHit, iBypass, iAttrNormal, iArrayEn;
  logic dHit, dBypass, dAttrNormal, dArrayEn;
  logic [14:0] iOffset, iOffset2;
  logic [13:0] dOffset, dOffset2;
  logic iHit2, iBy2, iAt2, iAr2, dHit2, dBy2, dAt2, dAr2;

  always #2.5 clk = ~clk;

  tcm_hit_decoder u_tcm_hit_decoder (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel), .cfgWrData(cfgWrData),
    .cfgRdSel(cfgRdSel), .cfgRdData(cfgRdData), .tcmStatus(tcmStatus),
    .iValid(iValid), .iAddr(iAddr), .iHit(iHit), .iBypass(iBypass), .iAttrNormal(iAttrNormal),
    .iArrayEn(iArrayEn), .iOffset(iOffset),
    .dValid(dValid), .dAddr(dAddr), .dHit(dHit), .dBypass(dBypass), .dAttrNormal(dAttrNormal),
    .dArrayEn(dArrayEn), .dOffset(dOffset)
  );

  tcm_hit_decoder #(.D_PRESENT(1'b0)) u_tcm_hit_decoder_noData (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel), .cfgWrData(cfgWrData),
    .cfgRdSel(cfgRdSel), .cfgRdData(rd2), .tcmStatus(st2),
    .iValid(iValid), .iAddr(iAddr), .iHit(iHit2), .iBypass(iBy2), .iAttrNormal(iAt2),
    .iArrayEn(iAr2), .iOffset(iOffset2),
    .dValid(dValid), .dAddr(dAddr), .dHit(dHit2), .dBypass(dBy2), .dAttrNormal(dAt2),
    .dArrayEn(dAr2), .dOffset(dOffset2)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  string phaseTag = "";

  bit            mEn[2];
  logic [AW-1:0] mBase[2];
  int            sizeLog2[2] = '{15, 14};

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit expHit(input int s, input bit v, input logic [AW-1:0] a);
    return v && mEn[s] && ((a >> sizeLog2[s]) == (mBase[s] >> sizeLog2[s]));
  endfunction

  function automatic logic [AW-1:0] expOff(input int s, input bit v, input logic [AW-1:0] a);
    return expHit(s, v, a) ? (a & ((32'd1 << sizeLog2[s]) - 1)) : '0;
  endfunction

  task automatic compareAll();
    string hTag, oTag;
    bit eI, eD;
    logic [AW-1:0] eRd;
    hTag = (phaseTag != "") ? phaseTag : "R4";
    oTag = (phaseTag != "") ? phaseTag : "R5";
    eI = expHit(0, iValid, iAddr);
    eD = expHit(1, dValid, dAddr);
    eRd = cfgRdSel ? (mBase[1] | 32'(mEn[1])) : (mBase[0] | 32'(mEn[0]));
    chk(iHit == eI, hTag, "iHit", iHit, eI);
    chk(dHit == eD, hTag, "dHit", dHit, eD);
    chk(32'(iOffset) == expOff(0, iValid, iAddr), oTag, "iOffset", iOffset, expOff(0, iValid, iAddr));
    chk(32'(dOffset) == expOff(1, dValid, dAddr), oTag, "dOffset", dOffset, expOff(1, dValid, dAddr));
    chk({iBypass, iAttrNormal, iArrayEn} == {3{eI}}, "R6", "iSide strobes", {iBypass, iAttrNormal, iArrayEn}, {3{eI}});
    chk({dBypass, dAttrNormal, dArrayEn} == {3{eD}}, "R6", "dSide strobes", {dBypass, dAttrNormal, dArrayEn}, {3{eD}});
    chk(cfgRdData == eRd, (phaseTag != "") ? phaseTag : "R3", "cfgRdData", cfgRdData, eRd);
    chk(tcmStatus == 16'h0507, "R2", "tcmStatus", tcmStatus, 16'h0507);
    // R9: build without data window
    chk({dHit2, dBy2, dAt2, dAr2} == 4'b0, "R9", "absent data strobes", {dHit2, dBy2, dAt2, dAr2}, 0);
    chk(dOffset2 == '0, "R9", "absent data offset", dOffset2, 0);
    chk(iHit2 == eI, "R9", "iHit in no-data build", iHit2, eI);
    chk(rd2 == (cfgRdSel ? '0 : eRd), "R9", "no-data readback", rd2, cfgRdSel ? '0 : eRd);
    chk(st2 == 16'h0007, "R9", "no-data status", st2, 16'h0007);
  endtask

  task automatic cyc(input bit we, input bit ws, input logic [AW-1:0] wd, input bit rs,
                     input bit iv, input logic [AW-1:0] ia, input bit dv, input logic [AW-1:0] da);
    @(negedge clk);
    cfgWrEn = we; cfgWrSel = ws; cfgWrData = wd; cfgRdSel = rs;
    iValid = iv; iAddr = ia; dValid = dv; dAddr = da;
    #1;
    compareAll();
    @(posedge clk);
    if (we) begin
      mEn[ws]   = wd[0];
      mBase[ws] = wd[0] ? (wd & ~((32'd1 << sizeLog2[ws]) - 1)) : '0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    mEn = '{0, 0};
    mBase = '{0, 0};
    // R1: reset state, checked while reset is held
    repeat (2) @(negedge clk);
    phaseTag = "R1";
    compareAll();
    cfgRdSel = 1'b1; #1; compareAll();
    @(negedge clk);
    rstN = 1'b1;
    cyc(0, 0, 0, 0, 1, 32'h0000_0000, 1, 32'h0000_0000);
    phaseTag = "";

    // R3: junk low bits in base are dropped
    cyc(1, 0, 32'h0001_9235, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 32'h0001_8004, 0, 0);
    chk(cfgRdData == 32'h0001_8001, "R3", "aligned readback", cfgRdData, 32'h0001_8001);
    cyc(0, 0, 0, 0, 1, 32'h0001_FFFF, 0, 0);
    cyc(0, 0, 0, 0, 1, 32'h0002_0000, 0, 0);
    cyc(0, 0, 0, 0, 1, 32'h8001_8000, 0, 0);

    // R8: write and access in the same cycle use the old settings
    phaseTag = "R8";
    cyc(1, 1, 32'h2000_4001, 1, 0, 0, 1, 32'h2000_4010);
    chk(dHit == 1'b0, "R8", "same-cycle access", dHit, 0);
    phaseTag = "";
    cyc(0, 0, 0, 1, 0, 0, 1, 32'h2000_4010);
    chk(dHit == 1'b1 && dOffset == 14'h0010, "R8", "next-cycle hit", {dHit, dOffset}, {1'b1, 14'h0010});

    // R10: data write leaves instruction side alone
    phaseTag = "R10";
    cyc(1, 1, 32'h3000_0001, 0, 1, 32'h0001_8100, 1, 32'h3000_0000);
    cyc(0, 0, 0, 0, 1, 32'h0001_8100, 0, 0);
    chk(cfgRdData == 32'h0001_8001 && iHit, "R10", "instr side after data write", cfgRdData, 32'h0001_8001);
    phaseTag = "";

    // R7: disable wipes base, then re-enable at a new base
    phaseTag = "R7";
    cyc(1, 0, 32'h0001_8000, 0, 1, 32'h0001_8000, 0, 0);
    cyc(0, 0, 0, 0, 1, 32'h0001_8000, 0, 0);
    chk(iHit == 1'b0 && cfgRdData == 0, "R7", "disabled window", {iHit, cfgRdData}, 0);
    cyc(0, 0, 0, 0, 1, 32'h0000_0000, 0, 0);
    cyc(1, 0, 32'h0000_0001, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 32'h0000_7FFC, 0, 0);
    chk(iHit == 1'b1 && iOffset == 15'h7FFC, "R7", "re-enabled at zero", {iHit, iOffset}, {1'b1, 15'h7FFC});
    phaseTag = "";

    // R4 R5 R6 R9: mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] ia, da, wd;
      int pick;
      bit we, ws;
      pick = int'($urandom_range(0, 3));
      ia = mBase[0] | ($urandom & 32'h7FFF);
      da = mBase[1] | ($urandom & 32'h3FFF);
      if (pick == 1) ia = ia ^ (32'd1 << $urandom_range(15, 31));
      if (pick == 2) da = $urandom;
      if (pick == 3) da = da ^ (32'd1 << $urandom_range(14, 31));
      we = ($urandom_range(0, 15) == 0);
      ws = $urandom_range(0, 1) == 1;
      wd = $urandom;
      if ($urandom_range(0, 3) == 0) wd[0] = 1'b0; else wd[0] = 1'b1;
      cyc(we, ws, wd, $urandom_range(0, 1) == 1,
          $urandom_range(0, 5) != 0, ia, $urandom_range(0, 5) != 0, da);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule